// File: doc/BRIEF.md
# Block-transfer host register window

This block is the host-facing side of a block-transfer style management mailbox. The host sees four byte-wide locations, selected by a two-bit address: control/status, a data port, an interrupt mask, and a spare location. A host write to the data port appends a byte to the request buffer. A host read of the data port takes the next byte of a response that the management-side handler has loaded. Handshake flags in the control register coordinate the two sides. The block drives a single level interrupt line towards the host.

The message handler gets a one-cycle `req_ready` strobe each time the host rings the request doorbell. It reads request bytes through an index port and sees the raw write count, which can exceed the buffer size so that an overrun can be detected. It loads a response with `rsp_push` and then `rsp_commit`. It signals unsolicited attention with the level input `sms_atn_in`.

The response buffer is controlled by a three-state machine. The states are RSP_IDLE (nothing held), RSP_FILL (the handler is loading bytes) and RSP_DRAIN (the host is reading bytes). It has three transitions:
- RSP_IDLE to RSP_FILL on the first push.
- RSP_FILL to RSP_DRAIN on commit.
- RSP_DRAIN to RSP_IDLE when the host reads the last byte.

Top module: `bt_host_regs`

## Requirements
- R1: Address 0 reads control as {bmc_busy, host_busy, 0, sms_flag, b2h_flag, 0, 0, 0} (bit7 down to bit0), address 2 reads the mask as {000000, pending, enable}, and address 3 always reads 0xFF.
- R2: In a control write, a 1 in bit0 sets the request count to zero, a 1 in bit1 rewinds the response read pointer to the first byte, a 1 in bit3 clears b2h_flag, and a 1 in bit4 clears sms_flag. A 0 in any of these bits changes nothing.
- R3: Writing 1 to control bit6 inverts host_busy; writing 0 leaves it.
- R4: Writing 1 to control bit2 sets bmc_busy (bit7) and raises `req_ready` for exactly the one cycle after the write.
- R5: Every data-port write increments `req_count`, which saturates at its maximum value. The byte is stored at index count only while count is below DEPTH, so earlier bytes survive an overrun.
- R6: A data-port read returns the byte at the read pointer and advances the pointer. After the last committed byte is read the buffer is empty. A read of an empty buffer returns 0xFF.
- R7: A commit of a non-empty response clears bmc_busy, sets b2h_flag, and sets pending if enable is 1.
- R8: Mask bit0 is the interrupt enable and bit1 is pending. Writing 1 to bit1 while pending clears pending. `irq` equals pending from the cycle after each update.
- R9: A mask write that changes enable from 0 to 1 sets pending if b2h_flag or sms_flag is set. A write that changes enable from 1 to 0 clears pending.
- R10: A rising edge of `sms_atn_in` sets sms_flag when it is clear, and sets pending if enable is 1 and b2h_flag is 0. A falling edge clears sms_flag when it is set, and clears pending if b2h_flag is 0.
- R11: The synchronous `cold_rst` input clears enable and pending, and so lowers `irq`.
- R12: An active-low `rst_n` clears every flag, the counts, the pointers and `irq`.
- R13: Pushes during RSP_DRAIN are ignored. A commit with no pushed bytes does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cold_rst | input | 1 | synchronous interrupt-setup reset |
| host_addr | input | 2 | register select |
| host_wr | input | 1 | host write strobe |
| host_rd | input | 1 | host read strobe |
| host_wdata | input | 8 | host write data |
| host_rdata | output | 8 | host read data (combinational) |
| req_ready | output | 1 | request doorbell strobe |
| req_idx | input | IDX_W | request byte index |
| req_byte | output | 8 | request byte at req_idx |
| req_count | output | CNT_W | data-port writes since the last clear |
| rsp_push | input | 1 | load one response byte |
| rsp_data | input | 8 | response byte |
| rsp_commit | input | 1 | publish the loaded response |
| sms_atn_in | input | 1 | management attention level |
| irq | output | 1 | host interrupt |

## Verification
Read data is combinational. The bench therefore samples `host_rdata` one time unit after it drives the address, which is before the edge where the read pointer advances. Every other result comes from a register and is due on the clock edge that takes the stimulus. This covers the flags, the counts, `irq` and `req_ready`. The bench checks these one time unit after that edge. It checks `req_ready` again one cycle later to confirm that the strobe has dropped. An edge on `sms_atn_in` is detected on the edge that first samples the new level, so its flag and interrupt effects can be seen straight after that same edge.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_FILL  = 2'd1,
        RSP_DRAIN = 2'd2
    } rsp_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    localparam int CB_CLR_REQ  = 0;
    localparam int CB_REWIND   = 1;
    localparam int CB_DOORBELL = 2;
    localparam int CB_B2H      = 3;
    localparam int CB_SMS      = 4;
    localparam int CB_HBUSY    = 6;
    localparam int CB_BBUSY    = 7;

    localparam int MB_EN   = 0;
    localparam int MB_PEND = 1;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/bt_req_buf.sv
module bt_req_buf #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !clr && count < CAP) begin
            mem[count[IDX_W-1:0]] <= wdata;
        end
    end

    assign rd_byte = mem[rd_idx];

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1);
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clr) |=> $stable(count));
endmodule

// File: rtl/bt_rsp_buf.sv
module bt_rsp_buf
    import bt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       commit,
    input  logic       pop,
    input  logic       rewind,
    output logic [7:0] head_byte,
    output logic       committed
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

    rsp_state_e       st, st_nxt;
    logic [PTR_W-1:0] load_ptr, len, rptr;
    logic [7:0]       mem [DEPTH];
    logic             last;
    logic             take;

    assign last = (rptr + 1'b1) == len;
    assign take = push && !commit && (st != RSP_DRAIN) && (load_ptr < CAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RSP_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RSP_IDLE:  if (take)          st_nxt = RSP_FILL;
            RSP_FILL:  if (commit)        st_nxt = RSP_DRAIN;
            RSP_DRAIN: if (pop && last)   st_nxt = RSP_IDLE;
            default:                      st_nxt = RSP_IDLE;
        endcase
    end

    always_comb begin
        committed = (st == RSP_FILL) && commit;
        head_byte = (st == RSP_DRAIN) ? mem[rptr[IDX_W-1:0]] : IDLE_BYTE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_ptr <= '0;
            len      <= '0;
            rptr     <= '0;
        end else begin
            if (take) load_ptr <= load_ptr + 1'b1;
            if (committed) begin
                len      <= load_ptr;
                load_ptr <= '0;
                rptr     <= '0;
            end else if (st == RSP_DRAIN && pop) begin
                if (last) begin
                    rptr <= '0;
                    len  <= '0;
                end else begin
                    rptr <= rptr + 1'b1;
                end
            end else if (rewind) begin
                rptr <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) mem[load_ptr[IDX_W-1:0]] <= push_data;
    end

    assert_last_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSP_DRAIN && pop && last) |=> (st == RSP_IDLE && len == '0));
    assert_drain_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSP_DRAIN) |-> (len != '0 && rptr < len));
    assert_drain_no_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSP_DRAIN) |-> load_ptr == '0);
    assert_empty_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RSP_IDLE && commit && !push) |=> st == RSP_IDLE);
endmodule

// File: rtl/bt_irq_ctl.sv
module bt_irq_ctl
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_rst,
    input  logic       mask_wr,
    input  logic [1:0] mask_wdata,
    input  logic       b2h_flag,
    input  logic       sms_flag,
    input  logic       commit_evt,
    input  logic       sms_rise,
    input  logic       sms_fall,
    output logic       en,
    output logic       pend,
    output logic       irq
);
    logic en_nxt, pend_nxt;

    always_comb begin
        en_nxt   = en;
        pend_nxt = pend;
        if (mask_wr) begin
            if (mask_wdata[MB_EN] && !en) begin
                en_nxt = 1'b1;
                if (b2h_flag || sms_flag) pend_nxt = 1'b1;
            end else if (!mask_wdata[MB_EN] && en) begin
                en_nxt   = 1'b0;
                pend_nxt = 1'b0;
            end
            if (mask_wdata[MB_PEND] && pend_nxt) pend_nxt = 1'b0;
        end
        if (commit_evt && en_nxt) pend_nxt = 1'b1;
        if (sms_rise && en_nxt && !b2h_flag) pend_nxt = 1'b1;
        if (sms_fall && !b2h_flag) pend_nxt = 1'b0;
        if (cold_rst) begin
            en_nxt   = 1'b0;
            pend_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            pend <= 1'b0;
        end else begin
            en   <= en_nxt;
            pend <= pend_nxt;
        end
    end

    assign irq = pend;

    assert_cold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst |=> (!en && !irq));
    assert_pend_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> en);
    assert_disable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_wdata[MB_EN] && en) |=> !irq);
    assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[MB_PEND] && pend && !commit_evt && !sms_rise) |=> !irq);
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
    import bt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_idx,
    output logic [7:0]       req_byte,
    output logic [CNT_W-1:0] req_count,
    input  logic             rsp_push,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_commit,
    input  logic             sms_atn_in,
    output logic             irq
);
    reg_sel_e   sel;
    logic       wr_ctrl, wr_data, wr_mask, rd_data;
    logic       b2h, sms, hbusy, bbusy, sms_q;
    logic       sms_rise_evt, sms_fall_evt;
    logic       committed;
    logic       en, pend;
    logic [7:0] head_byte;

    assign sel     = reg_sel_e'(host_addr);
    assign wr_ctrl = host_wr && sel == SEL_CTRL;
    assign wr_data = host_wr && sel == SEL_DATA;
    assign wr_mask = host_wr && sel == SEL_MASK;
    assign rd_data = host_rd && sel == SEL_DATA;

    assign sms_rise_evt = sms_atn_in && !sms_q && !sms;
    assign sms_fall_evt = !sms_atn_in && sms_q && sms;

    bt_req_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_ctrl && host_wdata[CB_CLR_REQ]),
        .wr     (wr_data),
        .wdata  (host_wdata),
        .rd_idx (req_idx),
        .rd_byte(req_byte),
        .count  (req_count)
    );

    bt_rsp_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rsp_push),
        .push_data(rsp_data),
        .commit   (rsp_commit),
        .pop      (rd_data),
        .rewind   (wr_ctrl && host_wdata[CB_REWIND]),
        .head_byte(head_byte),
        .committed(committed)
    );

    bt_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_rst  (cold_rst),
        .mask_wr   (wr_mask),
        .mask_wdata(host_wdata[1:0]),
        .b2h_flag  (b2h),
        .sms_flag  (sms),
        .commit_evt(committed),
        .sms_rise  (sms_rise_evt),
        .sms_fall  (sms_fall_evt),
        .en        (en),
        .pend      (pend),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b2h       <= 1'b0;
            sms       <= 1'b0;
            hbusy     <= 1'b0;
            bbusy     <= 1'b0;
            sms_q     <= 1'b0;
            req_ready <= 1'b0;
        end else begin
            sms_q     <= sms_atn_in;
            req_ready <= wr_ctrl && host_wdata[CB_DOORBELL];
            if (wr_ctrl) begin
                if (host_wdata[CB_B2H])      b2h   <= 1'b0;
                if (host_wdata[CB_SMS])      sms   <= 1'b0;
                if (host_wdata[CB_HBUSY])    hbusy <= ~hbusy;
                if (host_wdata[CB_DOORBELL]) bbusy <= 1'b1;
            end
            if (committed) begin
                bbusy <= 1'b0;
                b2h   <= 1'b1;
            end
            if (sms_rise_evt) sms <= 1'b1;
            if (sms_fall_evt) sms <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  host_rdata = {bbusy, hbusy, 1'b0, sms, b2h, 3'b000};
            SEL_DATA:  host_rdata = head_byte;
            SEL_MASK:  host_rdata = {6'b0, pend, en};
            default:   host_rdata = IDLE_BYTE;
        endcase
    end

    assert_doorbell_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && host_wdata[CB_DOORBELL] && !committed) |=> (req_ready && bbusy));
    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !(wr_ctrl && host_wdata[CB_DOORBELL])) |=> !req_ready);
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && host_wdata[CB_HBUSY]) |=> hbusy != $past(hbusy));
    assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        committed |=> (b2h && !bbusy));
endmodule

// File: tb/tb_bt_host_regs.sv
module tb_bt_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int CNT_W = 8;
    localparam int IDX_W = 6;

    logic clk = 0, rst_n = 0, cold_rst = 0;
    logic [1:0] host_addr = 0;
    logic host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic req_ready;
    logic [IDX_W-1:0] req_idx = 0;
    logic [7:0] req_byte;
    logic [CNT_W-1:0] req_count;
    logic rsp_push = 0, rsp_commit = 0, sms_atn_in = 0, irq;
    logic [7:0] rsp_data = 0;

    int total = 0, bad = 0;
    logic [7:0] ref_buf [DEPTH];
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    bt_host_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) dut (.*);

    function automatic logic [7:0] exp_ctrl(bit b2h, bit sms, bit hb, bit bb);
        return {bb, hb, 1'b0, sms, b2h, 3'b000};
    endfunction
    function automatic logic [7:0] exp_mask(bit en, bit pend);
        return {6'b0, pend, en};
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [1:0] a, logic [7:0] v);
        @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1;
        @(posedge clk); #1 host_wr = 0;
    endtask
    task automatic hr(logic [1:0] a, output logic [7:0] v);
        @(negedge clk); host_addr = a; host_rd = 1; #1 v = host_rdata;
        @(posedge clk); #1 host_rd = 0;
    endtask
    task automatic push(logic [7:0] v);
        @(negedge clk); rsp_data = v; rsp_push = 1;
        @(posedge clk); #1 rsp_push = 0;
    endtask
    task automatic commit();
        @(negedge clk); rsp_commit = 1;
        @(posedge clk); #1 rsp_commit = 0;
    endtask
    task automatic set_sms(logic v);
        @(negedge clk); sms_atn_in = v;
        @(posedge clk); #1;
    endtask
    task automatic rchk(string tag, logic [1:0] a, logic [7:0] e);
        logic [7:0] v;
        hr(a, v);
        chk(tag, v, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20151));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // reset state
        rchk("R12 ctrl", 0, exp_ctrl(0,0,0,0));
        rchk("R12 mask", 2, exp_mask(0,0));
        chk("R12 irq", irq, 0);
        chk("R12 count", req_count, 0);
        rchk("R6 empty read", 1, 8'hFF);
        rchk("R1 spare", 3, 8'hFF);
        // host busy toggle
        hw(0, 8'h40); rchk("R3 toggle on", 0, exp_ctrl(0,0,1,0));
        hw(0, 8'h40); rchk("R3 toggle off", 0, exp_ctrl(0,0,0,0));
        hw(0, 8'h00); rchk("R2 zero write", 0, exp_ctrl(0,0,0,0));
        // random request / response rounds
        for (int it = 0; it < 8; it++) begin
            int len, rlen;
            len = 1 + int'($urandom % DEPTH);
            hw(0, 8'h01);
            chk("R2 clear count", req_count, 0);
            for (int i = 0; i < len; i++) begin
                ref_buf[i] = 8'($urandom);
                hw(1, ref_buf[i]);
            end
            chk("R5 count", req_count, len);
            for (int i = 0; i < len; i++) begin
                req_idx = IDX_W'(i); #1;
                chk("R5 stored byte", req_byte, ref_buf[i]);
            end
            hw(0, 8'h04);
            chk("R4 strobe high", req_ready, 1);
            rchk("R4 busy set", 0, exp_ctrl(0,0,0,1));
            chk("R4 strobe low", req_ready, 0);
            rlen = 1 + int'($urandom % 16);
            for (int i = 0; i < rlen; i++) begin
                ref_buf[i] = 8'($urandom);
                push(ref_buf[i]);
            end
            commit();
            rchk("R7 commit flags", 0, exp_ctrl(1,0,0,0));
            for (int i = 0; i < rlen; i++) rchk("R6 response byte", 1, ref_buf[i]);
            rchk("R6 drained", 1, 8'hFF);
            hw(0, 8'h08);
            rchk("R2 b2h clear", 0, exp_ctrl(0,0,0,0));
        end
        // overrun
        hw(0, 8'h01);
        for (int i = 0; i < DEPTH + 3; i++) hw(1, 8'(i));
        chk("R5 overrun count", req_count, DEPTH + 3);
        req_idx = IDX_W'(DEPTH - 1); #1;
        chk("R5 last kept", req_byte, DEPTH - 1);
        req_idx = 0; #1;
        chk("R5 first kept", req_byte, 0);
        hw(0, 8'h01);
        chk("R2 clear after overrun", req_count, 0);
        // rewind
        push(8'hA1); push(8'hA2); push(8'hA3); commit();
        rchk("R6 b0", 1, 8'hA1); rchk("R6 b1", 1, 8'hA2);
        hw(0, 8'h02);
        rchk("R2 rewind b0", 1, 8'hA1); rchk("R2 rewind b1", 1, 8'hA2);
        rchk("R2 rewind b2", 1, 8'hA3); rchk("R6 empty", 1, 8'hFF);
        // push during drain ignored
        push(8'h11); push(8'h22); commit(); push(8'hEE);
        rchk("R13 b0", 1, 8'h11); rchk("R13 b1", 1, 8'h22);
        rchk("R13 no extra", 1, 8'hFF);
        hw(0, 8'h08);
        commit();
        rchk("R13 empty commit flags", 0, exp_ctrl(0,0,0,0));
        rchk("R13 empty commit data", 1, 8'hFF);
        // interrupts
        hw(2, 8'h01);
        rchk("R8 enable", 2, exp_mask(1,0)); chk("R8 irq low", irq, 0);
        push(8'h5A); commit();
        chk("R7 irq raise", irq, 1); rchk("R7 pending", 2, exp_mask(1,1));
        hw(2, 8'h03);
        chk("R8 ack irq", irq, 0); rchk("R8 ack mask", 2, exp_mask(1,0));
        hw(2, 8'h00); hw(2, 8'h01);
        chk("R9 enable with b2h", irq, 1);
        hw(2, 8'h00);
        chk("R9 disable drops", irq, 0); rchk("R9 mask off", 2, exp_mask(0,0));
        rchk("R6 byte", 1, 8'h5A); hw(0, 8'h08);
        // SMS attention
        hw(2, 8'h01);
        set_sms(1);
        chk("R10 rise irq", irq, 1); rchk("R10 flag", 0, exp_ctrl(0,1,0,0));
        set_sms(0);
        chk("R10 fall irq", irq, 0); rchk("R10 flag clr", 0, exp_ctrl(0,0,0,0));
        hw(2, 8'h00); push(8'h33); commit(); hw(2, 8'h01); hw(2, 8'h03);
        chk("R9 ack", irq, 0);
        set_sms(1);
        chk("R10 masked by b2h", irq, 0); rchk("R10 flag b2h", 0, exp_ctrl(1,1,0,0));
        set_sms(0);
        rchk("R10 flag drop", 0, exp_ctrl(1,0,0,0));
        rchk("R6 byte2", 1, 8'h33); hw(0, 8'h08);
        set_sms(1);
        chk("R10 rise again", irq, 1);
        hw(0, 8'h10);
        rchk("R2 sms clear", 0, exp_ctrl(0,0,0,0)); chk("R2 pend kept", irq, 1);
        hw(2, 8'h03); set_sms(0);
        chk("R10 fall no flag", irq, 0);
        // cold reset
        set_sms(1);
        chk("R11 pre", irq, 1);
        @(negedge clk) cold_rst = 1; @(posedge clk); #1 cold_rst = 0;
        chk("R11 irq", irq, 0); rchk("R11 mask", 2, exp_mask(0,0));
        set_sms(0);
        rchk("R1 spare end", 3, 8'hFF);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule